// File: doc/BRIEF.md
# LCD raster sync timing generator

This block produces the timing skeleton of a raster LCD panel. It divides the core clock down to a pixel rate, then walks each line through sync, back porch, active pixels and front porch, and walks the frame through the same four phases counted in lines. From that walk it drives a pixel clock, a line sync, a frame sync and a data-enable, together with the column and row index of the pixel being shown. Pixel data fetch and colour lookup sit elsewhere and follow `de_o`, `px_o` and `ln_o`.

All timing comes from static configuration inputs. The active width is given in units of 16 pixels and the active line count is given minus one, split into a low field and one extra top bit. Each of the three clock-like outputs has its own polarity. The two syncs can be moved so that they change on the falling pixel clock edge instead of the rising one. Dropping the raster enable lets the current frame finish before the engine goes idle. A one-cycle pulse marks the end of every frame.

Top module: `lcdt_raster_top`

## Requirements
- R1: The pixel period is `max(div_i, 2)` core cycles. `pix_en_o` is high for one core cycle per period. The uninverted `pclk_o` rises in the cycle where the pixel counters advance and falls `floor(period/2)` cycles later.
- R2: Each line has `(ppl_i + 1) * 16` active pixels. During them `px_o` counts from 0 up to that number minus 1. Outside them `px_o` is 0.
- R3: Each frame has `L + 1` active lines, where `L = {lpp_hi_i, lpp_lo_i}` and `lpp_hi_i` is bit 10. During active lines `ln_o` counts from 0 up to `L`. Outside them `ln_o` is 0.
- R4: A line runs sync, back porch, active, front porch, lasting `hsw_i`, `hbp_i`, active and `hfp_i` pixels. A frame runs the same four phases counted in lines, using `vsw_i`, `vbp_i`, active and `vfp_i`. Any sync or porch programmed as 0 lasts 1.
- R5: `de_o` is high only when the pixel lies in both the horizontal and the vertical active phase.
- R6: The line sync is active during horizontal sync pixels. The frame sync is active during every pixel of vertical sync lines. Each of `hsync_o`, `vsync_o` and `pclk_o` is active-high when its invert input is 0 and active-low when it is 1.
- R7: When `align_en_i` and `align_fall_i` are both 1, the sync outputs change only at the falling edge of the uninverted pixel clock. Otherwise they change at its rising edge.
- R8: `frame_done_o` pulses for one core cycle at the end of each frame. If `raster_en_i` is low at that moment the engine stops. It then shows no data-enable, inactive syncs and no further pulses.
- R9: When the engine is idle and `raster_en_i` is high, the next pixel tick starts a frame at the first sync pixel of the first line.
- R10: During reset, `de_o`, `frame_done_o`, `px_o` and `ln_o` are 0, and the syncs sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| raster_en_i | input | 1 | run request |
| div_i | input | 8 | pixel clock divisor (values below 2 act as 2) |
| ppl_i | input | PPL_W | active width in 16-pixel units, minus one |
| lpp_lo_i | input | 10 | active lines minus one, bits 9:0 |
| lpp_hi_i | input | 1 | active lines minus one, bit 10 |
| hsw_i | input | 6 | line sync width in pixels |
| hbp_i | input | 8 | horizontal back porch in pixels |
| hfp_i | input | 8 | horizontal front porch in pixels |
| vsw_i | input | 6 | frame sync width in lines |
| vbp_i | input | 8 | vertical back porch in lines |
| vfp_i | input | 8 | vertical front porch in lines |
| inv_pclk_i | input | 1 | invert pixel clock |
| inv_hs_i | input | 1 | invert line sync |
| inv_vs_i | input | 1 | invert frame sync |
| align_en_i | input | 1 | enable sync edge alignment |
| align_fall_i | input | 1 | with alignment, change syncs on falling pixel edge |
| pclk_o | output | 1 | pixel clock |
| pix_en_o | output | 1 | one-cycle pixel tick |
| hsync_o | output | 1 | line sync |
| vsync_o | output | 1 | frame sync |
| de_o | output | 1 | data enable |
| px_o | output | PPL_W+4 | active column index |
| ln_o | output | 11 | active row index |
| frame_done_o | output | 1 | end-of-frame pulse |

## Verification
The hardest behaviour to reach from the ports is the extra top line-count bit. Exercising it needs a frame of more than 1024 active lines. The stimulus keeps every other dimension at its minimum so that one such frame fits in a short run. It then counts data-enable cycles from the start of the frame and tracks the highest row index. The graceful stop is also awkward, because the enable must drop in the middle of a frame. The bench clears it a few cycles after a frame-done pulse. It then checks that the next pulse still arrives and that the outputs stay quiet for several frame times afterwards.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } lcdt_phase_e;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } lcdt_vis_t;

    // last count index of a programmed span; zero behaves as one
    function automatic logic [7:0] lcdt_last8(input logic [7:0] v);
        return (v == 8'd0) ? 8'd0 : v - 8'd1;
    endfunction

    function automatic logic [7:0] lcdt_eff_div(input logic [7:0] d);
        return (d < 8'd2) ? 8'd2 : d;
    endfunction

endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv
    import lcdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] div_i,
    output logic       tick_o,
    output logic       mid_o,
    output logic       lvl_o
);
    logic [7:0] cnt_q;
    logic [7:0] eff;
    logic [7:0] half;

    always_comb begin
        eff    = lcdt_eff_div(div_i);
        half   = eff >> 1;
        tick_o = (cnt_q >= eff - 8'd1);
        mid_o  = (cnt_q == half - 8'd1);
        lvl_o  = (cnt_q < half);
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 8'd1;
    end

    // R1: a divisor of at least two never yields back-to-back ticks
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic [W-1:0] sw_last_i,
    input  logic [W-1:0] bp_last_i,
    input  logic [W-1:0] act_last_i,
    input  logic [W-1:0] fp_last_i,
    output lcdt_phase_e  phase_o,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cur_last;
    logic         at_end;

    always_comb begin
        case (phase_o)
            PH_SYNC: cur_last = sw_last_i;
            PH_BACK: cur_last = bp_last_i;
            PH_ACT:  cur_last = act_last_i;
            default: cur_last = fp_last_i;
        endcase
        at_end = (cnt_o >= cur_last);
        wrap_o = step_i && at_end && (phase_o == PH_FRONT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_SYNC;
            cnt_o   <= '0;
        end else if (step_i) begin
            if (at_end) begin
                cnt_o   <= '0;
                phase_o <= lcdt_phase_e'(phase_o + 2'd1);
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    // R4: position only moves on a step
    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> ($stable(phase_o) && $stable(cnt_o)));

endmodule

// File: rtl/lcdt_raster_top.sv
module lcdt_raster_top
    import lcdt_pkg::*;
#(
    parameter int PPL_W     = 7,
    parameter bit EXT_LINES = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raster_en_i,
    input  logic [7:0]       div_i,
    input  logic [PPL_W-1:0] ppl_i,
    input  logic [9:0]       lpp_lo_i,
    input  logic             lpp_hi_i,
    input  logic [5:0]       hsw_i,
    input  logic [7:0]       hbp_i,
    input  logic [7:0]       hfp_i,
    input  logic [5:0]       vsw_i,
    input  logic [7:0]       vbp_i,
    input  logic [7:0]       vfp_i,
    input  logic             inv_pclk_i,
    input  logic             inv_hs_i,
    input  logic             inv_vs_i,
    input  logic             align_en_i,
    input  logic             align_fall_i,
    output logic             pclk_o,
    output logic             pix_en_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [PPL_W+3:0] px_o,
    output logic [10:0]      ln_o,
    output logic             frame_done_o
);
    localparam int HW = PPL_W + 4;
    localparam int VW = 11;

    logic          tick, mid, lvl;
    logic          run_q;
    logic          hs_q, vs_q;
    logic [HW-1:0] h_act_last, h_sw_last, h_bp_last, h_fp_last, hcnt;
    logic [VW-1:0] v_act_last, v_sw_last, v_bp_last, v_fp_last, vcnt;
    lcdt_phase_e   hph, vph;
    logic          h_step, h_wrap, v_wrap;
    lcdt_vis_t     vis;
    logic          late_sync;

    generate
        if (EXT_LINES) begin : g_lines_ext
            assign v_act_last = {lpp_hi_i, lpp_lo_i};
        end else begin : g_lines_base
            assign v_act_last = {1'b0, lpp_lo_i};
        end
    endgenerate

    always_comb begin
        h_act_last = {ppl_i, 4'hF};
        h_sw_last  = HW'(lcdt_last8({2'b00, hsw_i}));
        h_bp_last  = HW'(lcdt_last8(hbp_i));
        h_fp_last  = HW'(lcdt_last8(hfp_i));
        v_sw_last  = VW'(lcdt_last8({2'b00, vsw_i}));
        v_bp_last  = VW'(lcdt_last8(vbp_i));
        v_fp_last  = VW'(lcdt_last8(vfp_i));
    end

    lcdt_pixdiv u_div (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_i),
        .tick_o (tick),
        .mid_o  (mid),
        .lvl_o  (lvl)
    );

    assign h_step = tick && run_q;

    lcdt_axis #(.W(HW)) u_hax (
        .clk        (clk),
        .rst        (rst),
        .step_i     (h_step),
        .sw_last_i  (h_sw_last),
        .bp_last_i  (h_bp_last),
        .act_last_i (h_act_last),
        .fp_last_i  (h_fp_last),
        .phase_o    (hph),
        .cnt_o      (hcnt),
        .wrap_o     (h_wrap)
    );

    lcdt_axis #(.W(VW)) u_vax (
        .clk        (clk),
        .rst        (rst),
        .step_i     (h_wrap),
        .sw_last_i  (v_sw_last),
        .bp_last_i  (v_bp_last),
        .act_last_i (v_act_last),
        .fp_last_i  (v_fp_last),
        .phase_o    (vph),
        .cnt_o      (vcnt),
        .wrap_o     (v_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q        <= 1'b0;
            frame_done_o <= 1'b0;
        end else begin
            frame_done_o <= v_wrap;
            if (tick) begin
                if (!run_q && raster_en_i)      run_q <= 1'b1;
                else if (v_wrap && !raster_en_i) run_q <= 1'b0;
            end
        end
    end

    always_comb begin
        vis.hs = run_q && (hph == PH_SYNC);
        vis.vs = run_q && (vph == PH_SYNC);
        vis.de = run_q && (hph == PH_ACT) && (vph == PH_ACT);
    end

    // sync copies taken half a pixel period late
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else if (mid) begin
            hs_q <= vis.hs;
            vs_q <= vis.vs;
        end
    end

    assign late_sync = align_en_i && align_fall_i;

    always_comb begin
        pclk_o   = lvl ^ inv_pclk_i;
        pix_en_o = tick;
        hsync_o  = (late_sync ? hs_q : vis.hs) ^ inv_hs_i;
        vsync_o  = (late_sync ? vs_q : vis.vs) ^ inv_vs_i;
        de_o     = vis.de;
        px_o     = (run_q && hph == PH_ACT) ? hcnt : '0;
        ln_o     = (run_q && vph == PH_ACT) ? vcnt : '0;
    end

    // R8: the engine only goes idle together with a frame-done pulse
    a_r8_stop_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> frame_done_o);

    // R8: frame-done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

    // R2: column index stays inside the programmed width while showing data
    a_r2_px_in_range: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (px_o <= h_act_last));

    // R3: row index stays inside the programmed height while showing data
    a_r3_ln_in_range: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (ln_o <= v_act_last));

endmodule

// File: tb/lcdt_raster_top_tb_top.sv
module lcdt_raster_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raster_en_i = 1'b0;
    logic [7:0]  div_i = 8'd2;
    logic [6:0]  ppl_i = '0;
    logic [9:0]  lpp_lo_i = '0;
    logic        lpp_hi_i = 1'b0;
    logic [5:0]  hsw_i = 6'd1;
    logic [7:0]  hbp_i = 8'd1, hfp_i = 8'd1;
    logic [5:0]  vsw_i = 6'd1;
    logic [7:0]  vbp_i = 8'd1, vfp_i = 8'd1;
    logic        inv_pclk_i = 1'b0, inv_hs_i = 1'b0, inv_vs_i = 1'b0;
    logic        align_en_i = 1'b0, align_fall_i = 1'b0;
    logic        pclk_o, pix_en_o, hsync_o, vsync_o, de_o, frame_done_o;
    logic [10:0] px_o;
    logic [10:0] ln_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    lcdt_raster_top dut_i (
        .clk(clk), .rst(rst), .raster_en_i(raster_en_i), .div_i(div_i),
        .ppl_i(ppl_i), .lpp_lo_i(lpp_lo_i), .lpp_hi_i(lpp_hi_i),
        .hsw_i(hsw_i), .hbp_i(hbp_i), .hfp_i(hfp_i),
        .vsw_i(vsw_i), .vbp_i(vbp_i), .vfp_i(vfp_i),
        .inv_pclk_i(inv_pclk_i), .inv_hs_i(inv_hs_i), .inv_vs_i(inv_vs_i),
        .align_en_i(align_en_i), .align_fall_i(align_fall_i),
        .pclk_o(pclk_o), .pix_en_o(pix_en_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .px_o(px_o), .ln_o(ln_o),
        .frame_done_o(frame_done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected values from the requirements
    function automatic int span(input int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int e_div();
        return (div_i < 2) ? 2 : int'(div_i);
    endfunction
    function automatic int e_hact();
        return (int'(ppl_i) + 1) * 16;
    endfunction
    function automatic int e_vact();
        return int'(lpp_hi_i) * 1024 + int'(lpp_lo_i) + 1;
    endfunction
    function automatic int e_htot();
        return span(hsw_i) + span(hbp_i) + e_hact() + span(hfp_i);
    endfunction
    function automatic int e_vtot();
        return span(vsw_i) + span(vbp_i) + e_vact() + span(vfp_i);
    endfunction

    // measurement results
    int m_cyc, m_de, m_hs, m_vs, m_pe, m_align_bad, m_px_max, m_ln_max, m_first_bad;
    bit prev_pclk, prev_hs, prev_vs, seen_de;

    task automatic sample_one();
        bit raw_now, raw_prev, want;
        m_cyc++;
        raw_now  = pclk_o ^ inv_pclk_i;
        raw_prev = prev_pclk ^ inv_pclk_i;
        want     = (align_en_i && align_fall_i) ? 1'b0 : 1'b1;
        if (de_o) begin
            m_de++;
            if (!seen_de && (px_o != 0 || ln_o != 0)) m_first_bad++;
            seen_de = 1'b1;
            if (int'(px_o) > m_px_max) m_px_max = int'(px_o);
            if (int'(ln_o) > m_ln_max) m_ln_max = int'(ln_o);
        end else if (px_o != 0 && ln_o != 0 && !de_o && 0) begin
            m_first_bad++;
        end
        if (hsync_o != inv_hs_i) m_hs++;
        if (vsync_o != inv_vs_i) m_vs++;
        if (raw_now && !raw_prev) m_pe++;
        if ((hsync_o != prev_hs) || (vsync_o != prev_vs))
            if (!(raw_now != raw_prev && raw_now == want)) m_align_bad++;
        prev_pclk = pclk_o;
        prev_hs   = hsync_o;
        prev_vs   = vsync_o;
    endtask

    task automatic clear_meas();
        m_cyc = 0; m_de = 0; m_hs = 0; m_vs = 0; m_pe = 0;
        m_align_bad = 0; m_px_max = -1; m_ln_max = -1; m_first_bad = 0;
        seen_de = 1'b0;
    endtask

    // measure one whole frame between two frame-done pulses
    task automatic measure_frame();
        @(negedge clk);
        while (!frame_done_o) begin
            prev_pclk = pclk_o; prev_hs = hsync_o; prev_vs = vsync_o;
            @(negedge clk);
        end
        clear_meas();
        do begin
            sample_one();
            @(negedge clk);
        end while (!frame_done_o);
    endtask

    task automatic restart(input bit check_reset);
        rst = 1'b1;
        raster_en_i = 1'b0;
        repeat (3) @(negedge clk);
        if (check_reset) begin
            // R10: quiet outputs under reset
            check(de_o == 0 && frame_done_o == 0, "R10", {de_o, frame_done_o}, 0);
            check(hsync_o == inv_hs_i && vsync_o == inv_vs_i, "R10",
                  {hsync_o, vsync_o}, {inv_hs_i, inv_vs_i});
            check(px_o == 0 && ln_o == 0, "R10", int'(px_o) + int'(ln_o), 0);
        end
        rst = 1'b0;
        raster_en_i = 1'b1;
    endtask

    task automatic frame_checks(input string tag);
        int d, h, v;
        d = e_div(); h = e_htot(); v = e_vtot();
        measure_frame();
        check(m_cyc == d * h * v, "R4", m_cyc, d * h * v);
        check(m_pe == h * v, "R1", m_pe, h * v);
        check(m_de == d * e_hact() * e_vact(), "R5", m_de, d * e_hact() * e_vact());
        check(m_hs == d * span(hsw_i) * v, "R6", m_hs, d * span(hsw_i) * v);
        check(m_vs == d * span(vsw_i) * h, "R6", m_vs, d * span(vsw_i) * h);
        check(m_px_max == e_hact() - 1, "R2", m_px_max, e_hact() - 1);
        check(m_ln_max == e_vact() - 1, "R3", m_ln_max, e_vact() - 1);
        check(m_first_bad == 0, "R2", m_first_bad, 0);
        check(m_align_bad == 0, "R7", m_align_bad, 0);
        if (bad != 0) $display("  after config %s", tag);
    endtask

    // watchdog
    initial begin
        while (cycles < 190000) begin
            @(negedge clk);
            cycles++;
        end
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c));

        // directed: plain config, reset state checked
        div_i = 8'd3; ppl_i = 7'd1; lpp_lo_i = 10'd4; lpp_hi_i = 0;
        hsw_i = 6'd2; hbp_i = 8'd3; hfp_i = 8'd2; vsw_i = 6'd1; vbp_i = 8'd2; vfp_i = 8'd1;
        restart(1'b1);
        frame_checks("plain");

        // directed R1 and R4: divisor 0 acts as 2, zero spans act as 1
        div_i = 8'd0; hsw_i = 0; hbp_i = 0; hfp_i = 0; vsw_i = 0; vbp_i = 0; vfp_i = 0;
        ppl_i = 7'd0; lpp_lo_i = 10'd2;
        restart(1'b0);
        frame_checks("div0_zero");

        // directed R6 and R7: all inverted, syncs moved to falling edge
        div_i = 8'd4; hsw_i = 6'd3; hbp_i = 8'd1; hfp_i = 8'd2; vsw_i = 6'd2; vbp_i = 8'd1; vfp_i = 8'd1;
        inv_pclk_i = 1; inv_hs_i = 1; inv_vs_i = 1; align_en_i = 1; align_fall_i = 1;
        restart(1'b1);
        frame_checks("inverted_fall");

        // directed R7: select falling but alignment off stays on rising edge
        align_en_i = 0; div_i = 8'd5;
        restart(1'b0);
        frame_checks("fall_no_align");

        // constrained random configurations
        for (int k = 0; k < 6; k++) begin
            div_i = 8'($urandom_range(0, 4));
            ppl_i = 7'($urandom_range(0, 1));
            lpp_lo_i = 10'($urandom_range(0, 5));
            lpp_hi_i = 1'b0;
            hsw_i = 6'($urandom_range(0, 3)); hbp_i = 8'($urandom_range(0, 3));
            hfp_i = 8'($urandom_range(0, 3)); vsw_i = 6'($urandom_range(0, 3));
            vbp_i = 8'($urandom_range(0, 3)); vfp_i = 8'($urandom_range(0, 3));
            inv_pclk_i = 1'($urandom_range(0, 1)); inv_hs_i = 1'($urandom_range(0, 1));
            inv_vs_i = 1'($urandom_range(0, 1)); align_en_i = 1'($urandom_range(0, 1));
            align_fall_i = 1'($urandom_range(0, 1));
            restart(1'b0);
            frame_checks("random");
        end

        // directed R8 and R9: stop after the frame in progress, then restart
        begin
            int d, ft, n, lim;
            bit noisy;
            div_i = 8'd2; ppl_i = 0; lpp_lo_i = 10'd3; lpp_hi_i = 0;
            hsw_i = 1; hbp_i = 1; hfp_i = 1; vsw_i = 1; vbp_i = 1; vfp_i = 1;
            inv_pclk_i = 0; inv_hs_i = 0; inv_vs_i = 1; align_en_i = 0; align_fall_i = 0;
            d = e_div(); ft = d * e_htot() * e_vtot();
            restart(1'b0);
            @(negedge clk);
            while (!frame_done_o) @(negedge clk);
            repeat (10) @(negedge clk);
            raster_en_i = 1'b0;
            n = 0; lim = ft + 10;
            @(negedge clk);
            while (!frame_done_o && n < lim) begin n++; @(negedge clk); end
            check(frame_done_o == 1'b1, "R8", n, ft - 10 * 1);
            noisy = 1'b0;
            for (int i = 0; i < 3 * ft; i++) begin
                @(negedge clk);
                if (de_o || frame_done_o || hsync_o != inv_hs_i || vsync_o != inv_vs_i)
                    noisy = 1'b1;
            end
            check(!noisy, "R8", noisy, 0);
            raster_en_i = 1'b1;
            n = 0;
            @(negedge clk);
            while (!frame_done_o && n < 2 * ft) begin n++; @(negedge clk); end
            // R9: a full frame, started within one pixel period
            check(n + 1 >= ft && n + 1 <= ft + d, "R9", n + 1, ft);
        end

        // directed R3: line count using the top bit (1028 active lines)
        begin
            div_i = 8'd2; ppl_i = 0; lpp_lo_i = 10'd3; lpp_hi_i = 1'b1;
            hsw_i = 1; hbp_i = 1; hfp_i = 1; vsw_i = 1; vbp_i = 1; vfp_i = 1;
            inv_vs_i = 0;
            restart(1'b0);
            clear_meas();
            prev_pclk = pclk_o; prev_hs = hsync_o; prev_vs = vsync_o;
            @(negedge clk);
            while (!frame_done_o) begin sample_one(); @(negedge clk); end
            check(m_de == 2 * 16 * 1028, "R3", m_de, 2 * 16 * 1028);
            check(m_ln_max == 1027, "R3", m_ln_max, 1027);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule